// File: doc/BRIEF.md
# Loop port bypass controller

This block decides, for each port of a dual-port loop device, whether the device is removed from that loop. For every port it drives an active-low bypass request toward an external bypass circuit and a matching active-low indicator. A low request means the external circuit routes the loop around the device.

Bypass is sticky. A port goes into bypass when a bypass primitive sequence is reported for that port. Every port goes into bypass when any device fault is present: a loopback wrap test failure, a lost receive clock, a lost transmit clock or an interface hardware error. A port leaves bypass only when an enable primitive sequence is reported for it, self-test has completed and no fault is active.

Primitive detection, clock-loss detection and the external bypass hardware are outside the block. They appear here as clean synchronous strobes and levels. The receive path keeps working while a port is bypassed, so the primitive strobes are evaluated in every state.

Top module: `lpb_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every port is bypassed: all `byp_en_n` and `byp_led_n` bits are 0.
- R2: `byp_en_n[p]` is active low (0 = port p bypassed, 1 = port p on the loop), and `byp_led_n[p]` is 0 exactly when `byp_en_n[p]` is 0.
- R3: A one-cycle pulse on `bypass_prim[p]` puts port p into bypass at the next clock edge. The other port is not affected.
- R4: When any bit of `fault_flags` is 1 (bit 0 wrap test failure, bit 1 receive clock lost, bit 2 transmit clock lost, bit 3 interface hardware error), every port is bypassed at the next clock edge, whatever the primitive strobes are doing.
- R5: A pulse on `enable_prim[p]` with `selftest_done`=1, all `fault_flags` 0 and `bypass_prim[p]`=0 releases port p from bypass at the next clock edge, and the port stays on the loop afterwards.
- R6: An enable primitive that arrives while `selftest_done`=0 or a fault is active has no effect, and it is not stored: once the condition clears, the port stays bypassed until a new enable primitive arrives.
- R7: When `bypass_prim[p]` and `enable_prim[p]` are both 1 in the same cycle, port p ends up bypassed.
- R8: With no fault and no primitive strobe, each port keeps its state, whether bypassed or on the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fault_flags | input | NUM_FAULTS | Fault levels: wrap test, receive clock loss, transmit clock loss, interface hardware error |
| selftest_done | input | 1 | Self-test has completed |
| bypass_prim | input | NUM_PORTS | Per-port strobe: bypass primitive sequence seen |
| enable_prim | input | NUM_PORTS | Per-port strobe: enable primitive sequence seen |
| byp_en_n | output | NUM_PORTS | Per-port active-low bypass request to the external circuit |
| byp_led_n | output | NUM_PORTS | Per-port active-low bypass indicator |

## Verification
The bench builds the block with its default values: two ports and four fault flags. With these values the whole input space of a single decision is small. It contains every start state of both ports, all sixteen fault vectors, both self-test levels and every combination of the two strobe pairs, and the bench applies every one of these combinations from every start state. After each combination the bench spends an idle cycle with the release conditions met, which shows whether an ignored enable primitive was stored. It also applies reset in the middle of a run to check that the asynchronous reset forces bypass at once.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
  // Per-port bypass state; the encoding is the inverse of the pin level.
  typedef enum logic {
    ST_LOOP   = 1'b0,
    ST_BYPASS = 1'b1
  } port_state_e;

  // Position of each fault flag inside the fault vector.
  typedef enum int {
    FLT_WRAP    = 0,
    FLT_RX_CLK  = 1,
    FLT_TX_CLK  = 2,
    FLT_HW      = 3
  } fault_idx_e;

  localparam int FAULT_COUNT = 4;
endpackage

// File: rtl/lpb_rst_sync.sv
module lpb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lpb_fault_merge.sv
module lpb_fault_merge #(
  parameter int NUM_FAULTS = lpb_pkg::FAULT_COUNT
) (
  input  logic [NUM_FAULTS-1:0] fault_flags,
  input  logic                  selftest_done,
  output logic                  fault_any,
  output logic                  release_ok
);
  always_comb begin
    fault_any  = |fault_flags;
    release_ok = selftest_done && !fault_any;
  end
endmodule

// File: rtl/lpb_port_ctrl.sv
module lpb_port_ctrl
  import lpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_any,
  input  logic release_ok,
  input  logic bypass_prim,
  input  logic enable_prim,
  output logic byp_en_n,
  output logic byp_led_n
);
  port_state_e state_q;
  port_state_e state_d;
  logic        upd_en;

  always_comb begin
    state_d = state_q;
    if (fault_any || bypass_prim)        state_d = ST_BYPASS;
    else if (enable_prim && release_ok)  state_d = ST_LOOP;
    upd_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= ST_BYPASS;
    else if (upd_en) state_q <= state_d;
  end

  always_comb begin
    byp_en_n  = (state_q != ST_BYPASS);
    byp_led_n = (state_q != ST_BYPASS);
  end

  // R4
  fault_forces_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> (state_q == ST_BYPASS));

  // R3
  prim_forces_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_prim |=> (state_q == ST_BYPASS));

  // R5
  release_needs_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_BYPASS && state_q == ST_LOOP) |->
      ($past(enable_prim) && $past(release_ok)));

  // R6
  bypass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BYPASS && !enable_prim) |=> (state_q == ST_BYPASS));

  // R8
  loop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && !fault_any && !bypass_prim) |=> (state_q == ST_LOOP));
endmodule

// File: rtl/lpb_ctrl.sv
module lpb_ctrl #(
  parameter int NUM_PORTS  = 2,
  parameter int NUM_FAULTS = lpb_pkg::FAULT_COUNT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FAULTS-1:0] fault_flags,
  input  logic                  selftest_done,
  input  logic [NUM_PORTS-1:0]  bypass_prim,
  input  logic [NUM_PORTS-1:0]  enable_prim,
  output logic [NUM_PORTS-1:0]  byp_en_n,
  output logic [NUM_PORTS-1:0]  byp_led_n
);
  logic rst_sync_n;
  logic fault_any;
  logic release_ok;

  lpb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpb_fault_merge #(.NUM_FAULTS(NUM_FAULTS)) u_fault (
    .fault_flags   (fault_flags),
    .selftest_done (selftest_done),
    .fault_any     (fault_any),
    .release_ok    (release_ok)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    lpb_port_ctrl u_port (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .fault_any   (fault_any),
      .release_ok  (release_ok),
      .bypass_prim (bypass_prim[p]),
      .enable_prim (enable_prim[p]),
      .byp_en_n    (byp_en_n[p]),
      .byp_led_n   (byp_led_n[p])
    );
  end

  // R2
  led_tracks_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byp_led_n == byp_en_n);
endmodule

// File: tb/lpb_ctrl_test.sv
module lpb_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] fault_flags;
  logic       selftest_done;
  logic [1:0] bypass_prim;
  logic [1:0] enable_prim;
  logic [1:0] byp_en_n;
  logic [1:0] byp_led_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  lpb_ctrl uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_flags   (fault_flags),
    .selftest_done (selftest_done),
    .bypass_prim   (bypass_prim),
    .enable_prim   (enable_prim),
    .byp_en_n      (byp_en_n),
    .byp_led_n     (byp_led_n)
  );

  // exp_byp: 1 = port bypassed. Both pins must sit at the inverse level.
  task automatic check(input logic [1:0] exp_byp, input string tag);
    logic [3:0] act, exp;
    act = {byp_led_n, byp_en_n};
    exp = {~exp_byp, ~exp_byp};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s/R2 led,en act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] f, input logic d,
                       input logic [1:0] b, input logic [1:0] e);
    @(negedge clk);
    fault_flags   = f;
    selftest_done = d;
    bypass_prim   = b;
    enable_prim   = e;
  endtask

  function automatic logic [1:0] model(input logic [1:0] s, input logic [3:0] f,
                                       input logic d, input logic [1:0] b,
                                       input logic [1:0] e);
    logic [1:0] n;
    for (int p = 0; p < 2; p++) begin
      if (f != 0 || b[p])       n[p] = 1'b1;
      else if (e[p] && d)       n[p] = 1'b0;
      else                      n[p] = s[p];
    end
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fault_flags = '0; selftest_done = 1'b0; bypass_prim = '0; enable_prim = '0;
    repeat (3) @(negedge clk);
    check(2'b11, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(2'b11, "R1");

    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 16; f++)
        for (int d = 0; d < 2; d++)
          for (int b = 0; b < 4; b++)
            for (int e = 0; e < 4; e++) begin
              logic [1:0] nx;
              string tg;
              // reach start state s: R3 sets bypassed ports, R5 releases the rest
              drive(4'h0, 1'b1, 2'(s), ~2'(s));
              drive(4'h0, 1'b1, 2'b00, 2'b00);
              check(2'(s), (s == 3) ? "R3" : "R5");
              drive(4'(f), d[0], 2'(b), 2'(e));
              nx = model(2'(s), 4'(f), d[0], 2'(b), 2'(e));
              if (f != 0)                tg = "R4";
              else if ((b & e) != 0)     tg = "R7";
              else if (b != 0)           tg = "R3";
              else if (e != 0 && d == 0) tg = "R6";
              else if (e != 0)           tg = "R5";
              else                       tg = "R8";
              drive(4'h0, 1'b1, 2'b00, 2'b00);
              check(nx, tg);
              // idle with release allowed: an ignored enable must not act now
              drive(4'h0, 1'b1, 2'b00, 2'b00);
              check(nx, (e != 0 && (f != 0 || d == 0)) ? "R6" : "R8");
            end

    // R1: asynchronous reset from the on-loop state forces bypass at once
    drive(4'h0, 1'b1, 2'b00, 2'b11);
    drive(4'h0, 1'b1, 2'b00, 2'b00);
    check(2'b00, "R5");
    #1 rst_n = 1'b0;
    #1 check(2'b11, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(2'b11, "R1");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule